// File: doc/BRIEF.md
# Vertical Zero-Cluster Refresh Controller

This block is the digital model and control logic of a row-organised dynamic memory whose refresh effort depends on the data it holds. Rows are grouped into clusters of `CLUSTER` consecutive rows. Each cluster owns one indicator row, which holds a zero flag per column and a dirty flag. A zero flag of 1 promises that the column holds 0 in every row of the cluster, so that column need not be refreshed for the whole cluster. The indicator row is selected by the high-order bits of the row address.

Host writes land in the data array at once. A write also invalidates the cluster it touches: the cluster's zero flags go to 0 and its dirty flag goes to 1. Reads return stored data in the usual way. Refresh requests walk the rows in order. When the walk enters a cluster, the indicator row is fetched, which also restores its own charge. If the cluster is clean, the zero flags mask the refresh of their columns for the cluster's rows. If the cluster is dirty, every column is refreshed, and a per-column accumulator records whether any refreshed row held a 1. When the walk leaves that cluster, the accumulator becomes the new zero flags and the dirty flag drops, so the flags are rebuilt without extra row activations. The block reports, per refreshed row, the column enable vector, and it keeps running totals of refreshed and skipped cells.

Top module: `zc_refresh_ctrl`

## Requirements
- R1: Reset holds every data row at 0, every cluster dirty with zero flags 0, both counters at 0, and `ref_valid`, `ref_row`, `ref_first`, `ref_update`, `ref_col_en` and `rd_data` at 0.
- R2: `rd_en` returns the stored row on `rd_data` in the next cycle. A write to the same row in the same cycle is not visible until a later read. `rd_data` holds between reads.
- R3: Each `ref_req` refreshes the next row in ascending order, starting at row 0 after reset and wrapping after row `ROWS-1`. Its result appears in the following cycle with `ref_valid` = 1, and with `ref_first` = 1 exactly when the row number modulo `CLUSTER` is 0. Without a request, `ref_valid` is 0.
- R4: For a clean cluster (`ref_update` = 0), bit c of `ref_col_en` is 0 exactly when the cluster's zero flag for column c is 1, and it stays the same for all `CLUSTER` rows of the cluster.
- R5: For a dirty cluster, `ref_update` = 1 and `ref_col_en` is all ones for each of its rows.
- R6: When the refresh walk steps from a dirty cluster into the next cluster, the zero flag of each column becomes 1 exactly when that column read 0 in every row of the left cluster as those rows were refreshed. The cluster then becomes clean. The flags take effect on the cluster's next pass.
- R7: A host write clears the zero flags of its cluster and marks it dirty; a second write to a dirty cluster changes nothing more. If the write hits the cluster under refresh (in the cycle its row is refreshed or later within that pass), that row and the remaining rows of the cluster get all-ones enables, and the cluster stays dirty with no rebuild at its end.
- R8: With each refreshed row, `cnt_refreshed` grows by the number of ones in `ref_col_en`, and `cnt_suppressed` grows by the number of zeros. Both are updated in the same cycle as `ref_valid`, and they are unchanged otherwise.
- R9: The cluster of a row is given by row bits [ROW_W-1:log2(CLUSTER)]. A write marks only that cluster dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_row | input | ROW_W | Row written |
| wr_data | input | COLS | Data written |
| rd_en | input | 1 | Host read strobe |
| rd_row | input | ROW_W | Row read |
| rd_data | output | COLS | Read data, one cycle after `rd_en` |
| ref_req | input | 1 | Refresh the next row in sequence |
| ref_valid | output | 1 | A refresh result is presented this cycle |
| ref_row | output | ROW_W | Row that was refreshed |
| ref_first | output | 1 | Refreshed row opened its cluster (indicator row fetched) |
| ref_update | output | 1 | Cluster was in rebuild (dirty) mode |
| ref_col_en | output | COLS | Per-column refresh enable for that row |
| cnt_refreshed | output | CNT_W | Total refreshed column-row cells |
| cnt_suppressed | output | CNT_W | Total skipped column-row cells |

## Verification
Every result is due exactly one clock edge after its stimulus. This covers the read data, the refresh outcome of a request, and the counter step. A rebuilt flag set first shows up on the cluster's next pass, one full walk of `ROWS` requests later. A write is seen by the refresh result of the same cycle's request. The bench drives inputs on the falling edge and advances its behavioural model for that edge. It then compares every output on the next falling edge. Pass-level effects are checked by directed walks that write mid-pass and at cluster openings.

// File: rtl/zc_pkg.sv
package zc_pkg;
   // Operating mode of the cluster currently being refreshed.
   typedef enum logic {
      ZC_NORMAL = 1'b0,   // flags valid: zero columns skipped
      ZC_UPDATE = 1'b1    // flags stale: all columns refreshed, flags rebuilt
   } zc_mode_e;
endpackage

// File: rtl/zc_data_array.sv
module zc_data_array #(
   parameter int ROWS  = 64,
   parameter int COLS  = 16,
   parameter int ROW_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [COLS-1:0]  wr_data,
   input  logic             rd_en,
   input  logic [ROW_W-1:0] rd_row,
   output logic [COLS-1:0]  rd_data,
   input  logic [ROW_W-1:0] scan_row,
   output logic [COLS-1:0]  scan_data
);
   logic [COLS-1:0] cells_q [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) cells_q[r] <= '0;
      end else if (wr_en) begin
         cells_q[wr_row] <= wr_data;
      end
   end

   // Synchronous read port: old contents on a same-cycle write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= cells_q[rd_row];
   end

   // Refresh sense path: row content as restored by the refresh.
   assign scan_data = cells_q[scan_row];
endmodule

// File: rtl/zc_indicator_store.sv
module zc_indicator_store #(
   parameter int NCL  = 8,
   parameter int COLS = 16,
   parameter int CL_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inv_en,
   input  logic [CL_W-1:0] inv_cl,
   input  logic            wb_en,
   input  logic [CL_W-1:0] wb_cl,
   input  logic [COLS-1:0] wb_bits,
   input  logic [CL_W-1:0] rd_cl,
   output logic [COLS-1:0] rd_bits,
   output logic            rd_dirty
);
   logic [COLS-1:0] flag_q [NCL];
   logic [NCL-1:0]  dirty_q;

   // Rebuild is applied first; a host invalidation in the same cycle wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCL; c++) flag_q[c] <= '0;
         dirty_q <= '1;
      end else begin
         if (wb_en) begin
            flag_q[wb_cl]  <= wb_bits;
            dirty_q[wb_cl] <= 1'b0;
         end
         if (inv_en) begin
            flag_q[inv_cl]  <= '0;
            dirty_q[inv_cl] <= 1'b1;
         end
      end
   end

   assign rd_bits  = flag_q[rd_cl];
   assign rd_dirty = dirty_q[rd_cl];
endmodule

// File: rtl/zc_cluster_tracker.sv
module zc_cluster_tracker
   import zc_pkg::*;
#(
   parameter int COLS = 16,
   parameter int CL_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_req,
   input  logic            boundary,
   input  logic [CL_W-1:0] ref_cl,
   input  logic [COLS-1:0] ind_bits,
   input  logic            ind_dirty,
   input  logic [COLS-1:0] scan_data,
   input  logic            wr_en,
   input  logic [CL_W-1:0] wr_cl,
   output logic [COLS-1:0] row_en,
   output logic            row_update,
   output logic            wb_en,
   output logic [CL_W-1:0] wb_cl,
   output logic [COLS-1:0] wb_bits
);
   logic            act_valid;
   logic [CL_W-1:0] act_cl;
   zc_mode_e        act_mode;
   logic            act_spoil;
   logic [COLS-1:0] act_mask;
   logic [COLS-1:0] acc_q;

   logic            hit_act, hit_ref;
   zc_mode_e        cur_mode;
   logic            cur_spoil;
   logic [COLS-1:0] cur_mask, acc_base;

   assign hit_act = act_valid && wr_en && (wr_cl == act_cl);
   assign hit_ref = wr_en && (wr_cl == ref_cl);

   always_comb begin
      if (boundary) begin
         // Opening a cluster: fetch its indicator row.
         cur_mask  = ~ind_bits;
         cur_mode  = ind_dirty ? ZC_UPDATE : ZC_NORMAL;
         cur_spoil = 1'b0;
         acc_base  = '1;
      end else begin
         cur_mask  = act_mask;
         cur_mode  = act_mode;
         cur_spoil = act_spoil;
         acc_base  = acc_q;
      end
      if (hit_ref) begin
         cur_mask  = '1;
         cur_mode  = ZC_UPDATE;
         cur_spoil = 1'b1;
      end
   end

   assign row_en     = cur_mask;
   assign row_update = (cur_mode == ZC_UPDATE);

   // Leaving a cluster whose scan finished untouched commits the accumulator.
   assign wb_en   = ref_req && boundary && act_valid && (act_mode == ZC_UPDATE)
                    && !act_spoil && !hit_act;
   assign wb_cl   = act_cl;
   assign wb_bits = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act_cl    <= '0;
         act_mode  <= ZC_UPDATE;
         act_spoil <= 1'b0;
         act_mask  <= '1;
         acc_q     <= '1;
      end else if (ref_req) begin
         act_valid <= 1'b1;
         act_cl    <= ref_cl;
         act_mode  <= cur_mode;
         act_spoil <= cur_spoil;
         act_mask  <= cur_mask;
         acc_q     <= acc_base & ~scan_data;
      end else if (hit_act) begin
         act_mode  <= ZC_UPDATE;
         act_spoil <= 1'b1;
         act_mask  <= '1;
      end
   end
endmodule

// File: rtl/zc_refresh_ctrl.sv
module zc_refresh_ctrl #(
   parameter int ROWS    = 64,
   parameter int COLS    = 16,
   parameter int CLUSTER = 8,
   parameter int CNT_W   = 32,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int OFF_W  = $clog2(CLUSTER),
   localparam int NCL    = ROWS / CLUSTER,
   localparam int CL_W   = ROW_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [COLS-1:0]  wr_data,
   input  logic             rd_en,
   input  logic [ROW_W-1:0] rd_row,
   output logic [COLS-1:0]  rd_data,
   input  logic             ref_req,
   output logic             ref_valid,
   output logic [ROW_W-1:0] ref_row,
   output logic             ref_first,
   output logic             ref_update,
   output logic [COLS-1:0]  ref_col_en,
   output logic [CNT_W-1:0] cnt_refreshed,
   output logic [CNT_W-1:0] cnt_suppressed
);
   localparam int ONES_W = $clog2(COLS + 1);

   // Elaboration-time parameter checks.
   if (!(CLUSTER == 8 || CLUSTER == 16 || CLUSTER == 32)) begin : g_bad_cluster
      initial $fatal(1, "CLUSTER must be 8, 16 or 32");
   end
   if ((1 << ROW_W) != ROWS || NCL < 2) begin : g_bad_rows
      initial $fatal(1, "ROWS must be a power of two holding at least two clusters");
   end
   if (COLS < 1 || CNT_W < 8) begin : g_bad_width
      initial $fatal(1, "COLS and CNT_W out of range");
   end

   logic [ROW_W-1:0] ref_ptr;
   logic [CL_W-1:0]  ref_cl, wr_cl;
   logic             boundary;
   logic [COLS-1:0]  scan_data, ind_bits, row_en, wb_bits;
   logic             ind_dirty, row_update, wb_en;
   logic [CL_W-1:0]  wb_cl;
   logic [ONES_W-1:0] ones;

   assign ref_cl   = ref_ptr[ROW_W-1:OFF_W];
   assign wr_cl    = wr_row[ROW_W-1:OFF_W];
   assign boundary = (ref_ptr[OFF_W-1:0] == '0);

   zc_data_array #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
      .rd_en(rd_en), .rd_row(rd_row), .rd_data(rd_data),
      .scan_row(ref_ptr), .scan_data(scan_data)
   );

   zc_indicator_store #(.NCL(NCL), .COLS(COLS), .CL_W(CL_W)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .inv_en(wr_en), .inv_cl(wr_cl),
      .wb_en(wb_en), .wb_cl(wb_cl), .wb_bits(wb_bits),
      .rd_cl(ref_cl), .rd_bits(ind_bits), .rd_dirty(ind_dirty)
   );

   zc_cluster_tracker #(.COLS(COLS), .CL_W(CL_W)) u_track (
      .clk(clk), .rst_n(rst_n),
      .ref_req(ref_req), .boundary(boundary), .ref_cl(ref_cl),
      .ind_bits(ind_bits), .ind_dirty(ind_dirty), .scan_data(scan_data),
      .wr_en(wr_en), .wr_cl(wr_cl),
      .row_en(row_en), .row_update(row_update),
      .wb_en(wb_en), .wb_cl(wb_cl), .wb_bits(wb_bits)
   );

   assign ones = ONES_W'($countones(row_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_ptr        <= '0;
         ref_valid      <= 1'b0;
         ref_row        <= '0;
         ref_first      <= 1'b0;
         ref_update     <= 1'b0;
         ref_col_en     <= '0;
         cnt_refreshed  <= '0;
         cnt_suppressed <= '0;
      end else begin
         ref_valid <= ref_req;
         if (ref_req) begin
            ref_ptr        <= ref_ptr + 1'b1;
            ref_row        <= ref_ptr;
            ref_first      <= boundary;
            ref_update     <= row_update;
            ref_col_en     <= row_en;
            cnt_refreshed  <= cnt_refreshed + CNT_W'(ones);
            cnt_suppressed <= cnt_suppressed + (CNT_W'(COLS) - CNT_W'(ones));
         end
      end
   end
endmodule

// File: rtl/zc_refresh_ctrl_chk.sv
module zc_refresh_ctrl_chk #(
   parameter int COLS  = 16,
   parameter int CNT_W = 32,
   parameter int ROW_W = 6,
   parameter int OFF_W = 3,
   parameter int CL_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CL_W-1:0]  wr_cl,
   input logic             ref_req,
   input logic [ROW_W-1:0] ref_ptr,
   input logic             ref_valid,
   input logic [ROW_W-1:0] ref_row,
   input logic             ref_first,
   input logic             ref_update,
   input logic [COLS-1:0]  ref_col_en,
   input logic [CNT_W-1:0] cnt_refreshed,
   input logic [CNT_W-1:0] cnt_suppressed
);
   logic [CNT_W-1:0] total;
   assign total = cnt_refreshed + cnt_suppressed;

   assert_valid_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |=> ref_valid);
   assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_req |=> !ref_valid);
   assert_row_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |=> (ref_row == $past(ref_ptr)));
   assert_first_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |-> (ref_first == (ref_row[OFF_W-1:0] == '0)));
   assert_update_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_valid && ref_update) |-> (&ref_col_en));
   assert_write_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && wr_en && wr_cl == ref_ptr[ROW_W-1:OFF_W]) |=> (ref_update && (&ref_col_en)));
   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |-> (total == $past(total) + CNT_W'(COLS)));
   assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_valid |-> ($stable(cnt_refreshed) && $stable(cnt_suppressed)));
endmodule

bind zc_refresh_ctrl zc_refresh_ctrl_chk #(
   .COLS(COLS), .CNT_W(CNT_W), .ROW_W(ROW_W), .OFF_W(OFF_W), .CL_W(CL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cl(wr_cl),
   .ref_req(ref_req), .ref_ptr(ref_ptr), .ref_valid(ref_valid),
   .ref_row(ref_row), .ref_first(ref_first), .ref_update(ref_update),
   .ref_col_en(ref_col_en), .cnt_refreshed(cnt_refreshed),
   .cnt_suppressed(cnt_suppressed)
);

// File: tb/tb_zc_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_zc_refresh_ctrl;
   localparam int ROWS = 64, COLS = 16, CLUSTER = 8, CNT_W = 32;
   localparam int ROW_W = 6, NCL = ROWS / CLUSTER;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, ref_req = 1'b0;
   logic [ROW_W-1:0] wr_row = '0, rd_row = '0;
   logic [COLS-1:0]  wr_data = '0;
   logic [COLS-1:0]  rd_data, ref_col_en;
   logic             ref_valid, ref_first, ref_update;
   logic [ROW_W-1:0] ref_row;
   logic [CNT_W-1:0] cnt_refreshed, cnt_suppressed;

   always #2.5 clk = ~clk;   // 200 MHz

   zc_refresh_ctrl #(.ROWS(ROWS), .COLS(COLS), .CLUSTER(CLUSTER), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
      .rd_en(rd_en), .rd_row(rd_row), .rd_data(rd_data),
      .ref_req(ref_req), .ref_valid(ref_valid), .ref_row(ref_row),
      .ref_first(ref_first), .ref_update(ref_update), .ref_col_en(ref_col_en),
      .cnt_refreshed(cnt_refreshed), .cnt_suppressed(cnt_suppressed)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // Behavioural reference state.
   logic [COLS-1:0] m_data [ROWS];
   logic [COLS-1:0] m_flag [NCL];
   bit              m_dirty [NCL];
   int  m_ptr = 0;
   bit  m_have = 0, m_upd = 0, m_spoil = 0;
   int  m_cl = 0;
   logic [COLS-1:0] m_mask = '1, m_acc = '1;
   logic [COLS-1:0] e_rd = '0, e_en = '0;
   bit  e_valid = 0, e_first = 0, e_upd = 0, e_hit = 0;
   int  e_row = 0;
   longint e_cref = 0, e_csup = 0;
   bit  obs_upd [NCL];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic model_step(input bit w, input int wr_r, input logic [COLS-1:0] wd,
                             input bit r, input int rr, input bit q);
      bit hit_act;
      hit_act = m_have && w && (wr_r / CLUSTER == m_cl);
      e_valid = q;
      e_hit = 0;
      if (r) e_rd = m_data[rr];
      if (q) begin
         int row, cl;
         bit bnd;
         row = m_ptr; cl = row / CLUSTER; bnd = (row % CLUSTER) == 0;
         if (bnd) begin
            if (m_have && m_upd && !m_spoil && !hit_act) begin
               m_flag[m_cl] = m_acc;
               m_dirty[m_cl] = 0;
            end
            m_have = 1; m_cl = cl; m_upd = m_dirty[cl]; m_spoil = 0;
            m_mask = ~m_flag[cl]; m_acc = '1;
         end
         if (w && wr_r / CLUSTER == cl) begin
            m_mask = '1; m_upd = 1; m_spoil = 1; e_hit = 1;
         end
         m_acc = m_acc & ~m_data[row];
         e_row = row; e_first = bnd; e_en = m_mask; e_upd = m_upd;
         e_cref += $countones(m_mask);
         e_csup += COLS - $countones(m_mask);
         m_ptr = (m_ptr + 1) % ROWS;
      end else if (hit_act) begin
         m_mask = '1; m_upd = 1; m_spoil = 1;
      end
      if (w) begin
         m_flag[wr_r / CLUSTER] = '0;
         m_dirty[wr_r / CLUSTER] = 1;
         m_data[wr_r] = wd;
      end
   endtask

   task automatic cyc(input bit w, input int wr_r, input logic [COLS-1:0] wd,
                      input bit r, input int rr, input bit q);
      wr_en = w; wr_row = ROW_W'(wr_r); wr_data = wd;
      rd_en = r; rd_row = ROW_W'(rr); ref_req = q;
      model_step(w, wr_r, wd, r, rr, q);
      @(posedge clk);
      @(negedge clk);
      chk("R2 rd_data", 64'(rd_data), 64'(e_rd));
      chk("R3 ref_valid", 64'(ref_valid), 64'(e_valid));
      if (e_valid) begin
         chk("R3 ref_row", 64'(ref_row), 64'(e_row));
         chk("R3 ref_first", 64'(ref_first), 64'(e_first));
         chk("R5 ref_update", 64'(ref_update), 64'(e_upd));
         if (e_hit)      chk("R7 ref_col_en", 64'(ref_col_en), 64'(e_en));
         else if (e_upd) chk("R5 ref_col_en", 64'(ref_col_en), 64'(e_en));
         else            chk("R4 R6 ref_col_en", 64'(ref_col_en), 64'(e_en));
         if (ref_first) obs_upd[ref_row / CLUSTER] = ref_update;
      end
      chk("R8 cnt_refreshed", 64'(cnt_refreshed), 64'(e_cref));
      chk("R8 cnt_suppressed", 64'(cnt_suppressed), 64'(e_csup));
   endtask

   task automatic pass_idle();
      for (int i = 0; i < ROWS; i++) cyc(0, 0, '0, 0, 0, 1);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++) m_data[r] = '0;
      for (int c = 0; c < NCL; c++) begin m_flag[c] = '0; m_dirty[c] = 1; end
      repeat (3) @(negedge clk);
      // R1: reset values at the ports
      chk("R1 ref_valid", 64'(ref_valid), 0);
      chk("R1 ref_col_en", 64'(ref_col_en), 0);
      chk("R1 ref_update", 64'(ref_update), 0);
      chk("R1 rd_data", 64'(rd_data), 0);
      chk("R1 cnt_refreshed", 64'(cnt_refreshed), 0);
      chk("R1 cnt_suppressed", 64'(cnt_suppressed), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R2: rows read back as zero
      cyc(0, 0, '0, 1, 5, 0);
      cyc(0, 0, '0, 1, 63, 0);
      // R1 R5: first walk rebuilds every cluster; R6: second walk skips all
      pass_idle();
      pass_idle();
      // R7: writes; second write to a dirty cluster; R2 same-cycle read/write
      cyc(1, 3, 16'h0001, 0, 0, 0);
      cyc(1, 9, 16'h8000, 1, 9, 0);
      cyc(1, 17, 16'h00F0, 1, 3, 0);
      cyc(1, 23, 16'h0F00, 1, 17, 0);
      cyc(0, 0, '0, 1, 23, 0);
      cyc(0, 0, '0, 0, 0, 0);
      pass_idle();
      pass_idle();
      // R7: write into the cluster under refresh, mid-pass and at its first row
      for (int i = 0; i < ROWS; i++) begin
         bit w; int wr_r;
         w = (m_ptr == 33) || (m_ptr == 40);
         wr_r = (m_ptr == 33) ? 36 : 44;
         cyc(w, wr_r, 16'h0000, 0, 0, 1);
         if (m_ptr == 50) cyc(1, 52, 16'h0002, 0, 0, 0);
      end
      pass_idle();
      pass_idle();
      // Mixed traffic with sparse data and gaps between refresh requests
      for (int i = 0; i < 3000; i++) begin
         logic [COLS-1:0] d;
         d = COLS'($urandom & $urandom & $urandom);
         cyc(($urandom % 4) == 0, int'($urandom % ROWS), d,
             ($urandom % 3) == 0, int'($urandom % ROWS), ($urandom % 10) < 7);
      end
      // R9: cluster selection by high row bits
      while (m_ptr != 0) cyc(0, 0, '0, 0, 0, 1);
      pass_idle();
      pass_idle();
      cyc(1, 56, 16'h0000, 0, 0, 0);
      pass_idle();
      chk("R9 written cluster dirty", 64'(obs_upd[7]), 1);
      chk("R9 neighbour cluster clean", 64'(obs_upd[6]), 0);
      chk("R9 cluster zero clean", 64'(obs_upd[0]), 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R3 watchdog: actual=hung expected=finished");
         finish_run();
      end
   end
endmodule